// File: doc/BRIEF.md
# Asynchronous Transmit Stall Controller

This block supervises the asynchronous transmit side of a serial-bus link layer. It observes each quadlet pushed into the asynchronous transmit FIFO, the underflow and empty conditions of that FIFO, and the acknowledge codes returned by the bus for both FIFO-launched and data-mover-launched packets. From these it keeps five sticky status flags. It also produces two launch permits: one for any asynchronous packet and one for data-mover packets in particular.

The stall flag is the central state. It is raised when bad data reaches the FIFO interface. It is also raised when the FIFO runs dry inside a packet whose opening quadlet did not arrive through the dedicated first-quadlet port. While the stall flag is set, every asynchronous launch is refused. Only the FIFO clear command releases it. Isochronous traffic is not gated here. A non-complete acknowledge to a data-mover packet drops the mover enable in hardware, and software must set it again.

Software clears flags with write-1-to-clear pulses. A mask vector selects which flags drive the single interrupt line.

Top module: `atx_stall_ctrl`

## Requirements
- R1: A quadlet write (`wr_valid`) with `wr_bad_data` high sets the stall flag `flags[0]` at the next clock edge.
- R2: A `fifo_underflow` pulse sets `flags[0]` when the most recent packet-opening write (`wr_pkt_start`) had `wr_first` low. It does not set the flag when that write had `wr_first` high, or when no packet has opened since reset or since the last `fifo_clear`.
- R3: While `flags[0]` is set, `async_tx_ok` and `mover_tx_ok` are both low.
- R4: `flags[0]` is cleared only by `fifo_clear`. A write-1 pulse on `flag_clr[0]` leaves it set.
- R5: A packet-opening write whose `wr_tcode` is outside the valid set {0x0, 0x1, 0x4, 0x5, 0x6, 0x9, 0xA, 0xB} sets the code-error flag `flags[1]`. Codes inside the set leave it clear.
- R6: An `ack_valid` with `ack_src_mover` high and `ack_code` other than the complete code 0x1 sets `flags[2]` and clears `mover_en`. `mover_tx_ok` stays low until `mover_en_set` is pulsed. A complete acknowledge leaves `mover_en` unchanged.
- R7: An `ack_valid` with `ack_src_mover` low sets the FIFO-ack flag `flags[3]`, whatever the code is, and does not touch `mover_en`.
- R8: A rising edge of `fifo_empty` sets `flags[4]`. Holding `fifo_empty` high does not set it again after it has been cleared.
- R9: Flags 1 to 4 stay set until a 1 is written to the matching `flag_clr` bit.
- R10: When a set event and a clear (write-1 or `fifo_clear`) hit the same flag in the same cycle, the flag ends set.
- R11: `irq` is high exactly when some flag is set whose `irq_mask` bit is also set.
- R12: After reset all flags are 0, `mover_en` is 0, `async_tx_ok` is 1 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | A quadlet is written into the transmit FIFO this cycle |
| wr_first | input | 1 | The write uses the dedicated first-quadlet port |
| wr_pkt_start | input | 1 | The written quadlet opens a packet |
| wr_bad_data | input | 1 | Invalid data detected on the written quadlet |
| wr_tcode | input | TCODE_W | Decoded transaction code of the opening quadlet |
| fifo_underflow | input | 1 | The transmitter read past the end of FIFO data |
| fifo_empty | input | 1 | FIFO-empty level |
| fifo_clear | input | 1 | Software clear command for the transmit FIFO |
| ack_valid | input | 1 | An acknowledge was received |
| ack_src_mover | input | 1 | The acknowledge answers a data-mover packet (1) or a FIFO packet (0) |
| ack_code | input | ACK_W | Received acknowledge code |
| mover_en_set | input | 1 | Software pulse that sets the data-mover enable |
| flag_clr | input | NFLAG | Write-1-to-clear pulses, one per flag |
| irq_mask | input | NFLAG | Interrupt mask, one per flag |
| flags | output | NFLAG | Sticky flags: 0 stall, 1 code error, 2 mover ack error, 3 FIFO ack, 4 FIFO empty |
| irq | output | 1 | Masked OR of the flags |
| mover_en | output | 1 | Data-mover enable |
| async_tx_ok | output | 1 | Asynchronous launch permitted |
| mover_tx_ok | output | 1 | Data-mover launch permitted |

## Verification
The bench builds the block with its default parameters: 4-bit transaction codes with eight valid codes, a 4-bit acknowledge with complete coded as 0x1, code checking enabled and the mover enable reset to 0. These values expose both edges of the valid code list (0xB accepted, 0xC rejected) and the gap inside it (0x3). They also allow a non-complete code on the FIFO path, so the test shows that only the mover path drops the enable. Collisions between set and clear are driven for both the software-cleared flags and the stall flag.

// File: rtl/atx_stall_pkg.sv
package atx_stall_pkg;
   localparam int NFLAG       = 5;
   localparam int F_STALL     = 0;
   localparam int F_TCODE_ERR = 1;
   localparam int F_MOVER_ERR = 2;
   localparam int F_FIFO_ACK  = 3;
   localparam int F_EMPTY     = 4;
   // flags software may clear with write-1 pulses; stall is excluded
   localparam logic [NFLAG-1:0] SW_CLEARABLE = 5'b11110;
endpackage

// File: rtl/atx_tcode_check.sv
module atx_tcode_check #(
   parameter int TCODE_W = 4,
   parameter int NVALID  = 8,
   parameter logic [NVALID*TCODE_W-1:0] VALID_TCODES = '0,
   parameter bit CHECK_EN = 1'b1
) (
   input  logic [TCODE_W-1:0] tcode,
   output logic               invalid
);
   if (CHECK_EN) begin : g_check
      logic [NVALID-1:0] hit;
      for (genvar i = 0; i < NVALID; i++) begin : g_cmp
         assign hit[i] = (tcode == VALID_TCODES[i*TCODE_W +: TCODE_W]);
      end
      assign invalid = ~|hit;
   end else begin : g_nocheck
      logic unused_ok;
      assign unused_ok = ^tcode;
      assign invalid   = 1'b0;
   end
endmodule

// File: rtl/atx_pkt_tracker.sv
module atx_pkt_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_valid,
   input  logic wr_first,
   input  logic wr_pkt_start,
   input  logic wr_bad_data,
   input  logic fifo_underflow,
   input  logic fifo_empty,
   input  logic fifo_clear,
   output logic stall_event,
   output logic empty_event
);
   logic first_ok_q;
   logic empty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_ok_q <= 1'b1;
         empty_q    <= 1'b1;
      end else begin
         empty_q <= fifo_empty;
         if (fifo_clear)
            first_ok_q <= 1'b1;
         else if (wr_valid && wr_pkt_start)
            first_ok_q <= wr_first;
      end
   end

   assign stall_event = (wr_valid & wr_bad_data) | (fifo_underflow & ~first_ok_q);
   assign empty_event = fifo_empty & ~empty_q;
endmodule

// File: rtl/atx_flag_bank.sv
module atx_flag_bank #(
   parameter int N = 5,
   parameter logic [N-1:0] SW_MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_ev,
   input  logic [N-1:0] sw_clr,
   input  logic [N-1:0] hw_clr,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      logic clr_i;
      if (SW_MASK[i]) begin : g_sw
         assign clr_i = sw_clr[i] | hw_clr[i];
      end else begin : g_hw
         logic unused_sw;
         assign unused_sw = sw_clr[i];
         assign clr_i     = hw_clr[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          q[i] <= 1'b0;
         else if (set_ev[i])  q[i] <= 1'b1;
         else if (clr_i)      q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/atx_mover_gate.sv
module atx_mover_gate #(
   parameter int ACK_W = 4,
   parameter logic [ACK_W-1:0] ACK_DONE = 1,
   parameter bit EN_RST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_valid,
   input  logic             ack_src_mover,
   input  logic [ACK_W-1:0] ack_code,
   input  logic             en_set,
   output logic             mover_err,
   output logic             fifo_ack,
   output logic             en
);
   assign mover_err = ack_valid & ack_src_mover & (ack_code != ACK_DONE);
   assign fifo_ack  = ack_valid & ~ack_src_mover;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en <= EN_RST;
      else if (mover_err) en <= 1'b0;
      else if (en_set)    en <= 1'b1;
   end
endmodule

// File: rtl/atx_stall_ctrl.sv
module atx_stall_ctrl
   import atx_stall_pkg::*;
#(
   parameter int TCODE_W = 4,
   parameter int NVALID  = 8,
   parameter logic [NVALID*TCODE_W-1:0] VALID_TCODES =
      {4'hB, 4'hA, 4'h9, 4'h6, 4'h5, 4'h4, 4'h1, 4'h0},
   parameter bit CHECK_TCODE = 1'b1,
   parameter int ACK_W = 4,
   parameter logic [ACK_W-1:0] ACK_DONE = 1,
   parameter bit MOVER_EN_RST = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_valid,
   input  logic               wr_first,
   input  logic               wr_pkt_start,
   input  logic               wr_bad_data,
   input  logic [TCODE_W-1:0] wr_tcode,
   input  logic               fifo_underflow,
   input  logic               fifo_empty,
   input  logic               fifo_clear,
   input  logic               ack_valid,
   input  logic               ack_src_mover,
   input  logic [ACK_W-1:0]   ack_code,
   input  logic               mover_en_set,
   input  logic [NFLAG-1:0]   flag_clr,
   input  logic [NFLAG-1:0]   irq_mask,
   output logic [NFLAG-1:0]   flags,
   output logic               irq,
   output logic               mover_en,
   output logic               async_tx_ok,
   output logic               mover_tx_ok
);
   localparam int MAX_CODES = 1 << TCODE_W;

   if (TCODE_W < 1 || TCODE_W > 8) begin : g_bad_tw
      $error("TCODE_W out of range");
   end
   if (NVALID < 1 || NVALID > MAX_CODES) begin : g_bad_nv
      $error("NVALID must lie between 1 and 2**TCODE_W");
   end
   if (ACK_W < 1) begin : g_bad_aw
      $error("ACK_W must be positive");
   end

   logic stall_ev, empty_ev, tcode_bad, mover_err_ev, fifo_ack_ev;
   logic [NFLAG-1:0] set_vec, hw_clr_vec;

   atx_pkt_tracker i_trk (
      .clk, .rst_n, .wr_valid, .wr_first, .wr_pkt_start, .wr_bad_data,
      .fifo_underflow, .fifo_empty, .fifo_clear,
      .stall_event(stall_ev), .empty_event(empty_ev)
   );

   atx_tcode_check #(
      .TCODE_W(TCODE_W), .NVALID(NVALID),
      .VALID_TCODES(VALID_TCODES), .CHECK_EN(CHECK_TCODE)
   ) i_tc (
      .tcode(wr_tcode), .invalid(tcode_bad)
   );

   atx_mover_gate #(
      .ACK_W(ACK_W), .ACK_DONE(ACK_DONE), .EN_RST(MOVER_EN_RST)
   ) i_mv (
      .clk, .rst_n, .ack_valid, .ack_src_mover, .ack_code,
      .en_set(mover_en_set), .mover_err(mover_err_ev),
      .fifo_ack(fifo_ack_ev), .en(mover_en)
   );

   always_comb begin
      set_vec              = '0;
      set_vec[F_STALL]     = stall_ev;
      set_vec[F_TCODE_ERR] = wr_valid & wr_pkt_start & tcode_bad;
      set_vec[F_MOVER_ERR] = mover_err_ev;
      set_vec[F_FIFO_ACK]  = fifo_ack_ev;
      set_vec[F_EMPTY]     = empty_ev;
      hw_clr_vec           = '0;
      hw_clr_vec[F_STALL]  = fifo_clear;
   end

   atx_flag_bank #(.N(NFLAG), .SW_MASK(SW_CLEARABLE)) i_flags (
      .clk, .rst_n, .set_ev(set_vec), .sw_clr(flag_clr),
      .hw_clr(hw_clr_vec), .q(flags)
   );

   assign irq         = |(flags & irq_mask);
   assign async_tx_ok = ~flags[F_STALL];
   assign mover_tx_ok = async_tx_ok & mover_en;
endmodule

// File: rtl/atx_stall_ctrl_chk.sv
module atx_stall_ctrl_chk #(
   parameter int ACK_W = 4,
   parameter logic [ACK_W-1:0] ACK_DONE = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_valid,
   input logic             wr_bad_data,
   input logic             fifo_clear,
   input logic             ack_valid,
   input logic             ack_src_mover,
   input logic [ACK_W-1:0] ack_code,
   input logic [4:0]       flag_clr,
   input logic [4:0]       irq_mask,
   input logic [4:0]       flags,
   input logic             irq,
   input logic             mover_en,
   input logic             async_tx_ok,
   input logic             mover_tx_ok
);
   // R1
   bad_data_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_bad_data |=> flags[0]);
   // R3
   stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[0] |-> !async_tx_ok && !mover_tx_ok);
   // R4
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[0] && !fifo_clear |=> flags[0]);
   // R6
   mover_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid && ack_src_mover && ack_code != ACK_DONE |=> !mover_en && flags[2] && !mover_tx_ok);
   // R7
   fifo_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid && !ack_src_mover |=> flags[3]);
   // R9
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[4:1] != 4'b0 |=> ((flags[4:1] & ~flags[4:1]) == 4'b0) &&
         (($past(flags[4:1]) & ~$past(flag_clr[4:1]) & ~flags[4:1]) == 4'b0));
   // R11
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mask == 5'b0 |-> !irq);
endmodule

bind atx_stall_ctrl atx_stall_ctrl_chk #(.ACK_W(ACK_W), .ACK_DONE(ACK_DONE)) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_bad_data(wr_bad_data),
   .fifo_clear(fifo_clear), .ack_valid(ack_valid), .ack_src_mover(ack_src_mover),
   .ack_code(ack_code), .flag_clr(flag_clr), .irq_mask(irq_mask), .flags(flags),
   .irq(irq), .mover_en(mover_en), .async_tx_ok(async_tx_ok), .mover_tx_ok(mover_tx_ok)
);

// File: tb/test_atx_stall_ctrl.sv
`timescale 1ns/100ps
module test_atx_stall_ctrl;
   typedef struct packed {
      logic wr_valid, wr_first, wr_pkt_start, wr_bad_data;
      logic [3:0] wr_tcode;
      logic fifo_underflow, fifo_clear, ack_valid, ack_src_mover;
      logic [3:0] ack_code;
      logic [4:0] flag_clr;
      logic mover_en_set;
   } stim_t;
   typedef struct {
      logic [4:0] fl;
      logic en;
      string tag;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_valid = 0, wr_first = 0, wr_pkt_start = 0, wr_bad_data = 0;
   logic [3:0] wr_tcode = 0;
   logic fifo_underflow = 0, fifo_empty = 1, fifo_clear = 0;
   logic ack_valid = 0, ack_src_mover = 0, mover_en_set = 0;
   logic [3:0] ack_code = 0;
   logic [4:0] flag_clr = 0, irq_mask = 0;
   logic [4:0] flags;
   logic irq, mover_en, async_tx_ok, mover_tx_ok;

   stim_t s;
   logic lvl_empty = 1'b1;
   logic [4:0] mask_v = 5'b0;
   exp_t q[$];
   int checks = 0, fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   atx_stall_ctrl i_atx_stall_ctrl (
      .clk, .rst_n, .wr_valid, .wr_first, .wr_pkt_start, .wr_bad_data, .wr_tcode,
      .fifo_underflow, .fifo_empty, .fifo_clear, .ack_valid, .ack_src_mover,
      .ack_code, .mover_en_set, .flag_clr, .irq_mask, .flags, .irq, .mover_en,
      .async_tx_ok, .mover_tx_ok
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   // driver: applies one cycle of stimulus and queues the expected result
   task automatic step(input logic [4:0] ef, input logic een, input string tag);
      exp_t e;
      @(negedge clk);
      {wr_valid, wr_first, wr_pkt_start, wr_bad_data} = {s.wr_valid, s.wr_first, s.wr_pkt_start, s.wr_bad_data};
      wr_tcode = s.wr_tcode;
      fifo_underflow = s.fifo_underflow;
      fifo_clear = s.fifo_clear;
      ack_valid = s.ack_valid;
      ack_src_mover = s.ack_src_mover;
      ack_code = s.ack_code;
      flag_clr = s.flag_clr;
      mover_en_set = s.mover_en_set;
      fifo_empty = lvl_empty;
      irq_mask = mask_v;
      e.fl = ef; e.en = een; e.tag = tag;
      q.push_back(e);
      s = '0;
   endtask

   // monitor: compares outputs after each clock edge
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            check(flags == e.fl, e.tag, "flags", flags, e.fl);
            check(mover_en == e.en, e.tag, "mover_en", mover_en, e.en);
            // R3: launch permits follow the stall flag
            check(async_tx_ok == !e.fl[0], e.tag, "R3 async_tx_ok", async_tx_ok, !e.fl[0]);
            check(mover_tx_ok == (!e.fl[0] && e.en), e.tag, "R3 mover_tx_ok", mover_tx_ok, !e.fl[0] && e.en);
            // R11
            check(irq == |(e.fl & irq_mask), e.tag, "R11 irq", irq, |(e.fl & irq_mask));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog timeout");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      s = '0;
      repeat (3) @(negedge clk);
      // R12 reset state
      check(flags == 5'b0, "R12", "flags", flags, 0);
      check(mover_en == 1'b0, "R12", "mover_en", mover_en, 0);
      check(async_tx_ok == 1'b1, "R12", "async_tx_ok", async_tx_ok, 1);
      check(irq == 1'b0, "R12", "irq", irq, 0);
      rst_n = 1'b1;

      s.mover_en_set = 1; step(5'b00000, 1, "R6 enable set");
      s.wr_valid = 1; s.wr_first = 1; s.wr_pkt_start = 1; s.wr_tcode = 4'h1;
      step(5'b00000, 1, "R5 valid code 1");
      s.wr_valid = 1; s.wr_pkt_start = 1; s.wr_tcode = 4'h3;
      step(5'b00010, 1, "R5 invalid code 3");
      s.flag_clr = 5'b00010; step(5'b00000, 1, "R9 w1c code error");
      s.wr_valid = 1; s.wr_pkt_start = 1; s.wr_tcode = 4'hF; s.flag_clr = 5'b00010;
      step(5'b00010, 1, "R10 set beats w1c");
      s.flag_clr = 5'b00010; step(5'b00000, 1, "R9 clear again");
      s.wr_valid = 1; s.wr_pkt_start = 1; s.wr_tcode = 4'hB;
      step(5'b00000, 1, "R5 valid code B");
      s.wr_valid = 1; s.wr_pkt_start = 1; s.wr_tcode = 4'hC;
      step(5'b00010, 1, "R5 invalid code C");
      s.wr_valid = 1; s.wr_pkt_start = 0; s.wr_tcode = 4'hD;
      step(5'b00010, 1, "R9 non-opening write, flag held");
      s.flag_clr = 5'b00010; step(5'b00000, 1, "R9 clear");

      s.ack_valid = 1; s.ack_src_mover = 0; s.ack_code = 4'h2;
      step(5'b01000, 1, "R7 fifo ack");
      mask_v = 5'b01000; step(5'b01000, 1, "R11 unmasked");
      mask_v = 5'b10111; step(5'b01000, 1, "R11 masked");
      mask_v = 5'b11111;
      s.flag_clr = 5'b01000; step(5'b00000, 1, "R9 clear fifo ack");

      s.ack_valid = 1; s.ack_src_mover = 1; s.ack_code = 4'h1;
      step(5'b00000, 1, "R6 complete keeps enable");
      s.ack_valid = 1; s.ack_src_mover = 1; s.ack_code = 4'h4;
      step(5'b00100, 0, "R6 busy drops enable");
      step(5'b00100, 0, "R6 stays blocked");
      s.mover_en_set = 1; s.flag_clr = 5'b00100;
      step(5'b00000, 1, "R6 re-enable");

      lvl_empty = 1'b0; step(5'b00000, 1, "R8 not empty");
      lvl_empty = 1'b1; step(5'b10000, 1, "R8 becomes empty");
      s.flag_clr = 5'b10000; step(5'b00000, 1, "R8 cleared");
      step(5'b00000, 1, "R8 level held no reset");

      s.wr_valid = 1; s.wr_bad_data = 1; step(5'b00001, 1, "R1 bad data stall");
      s.flag_clr = 5'b11111; step(5'b00001, 1, "R4 w1c ignored");
      step(5'b00001, 1, "R4 stall holds");
      s.fifo_clear = 1; step(5'b00000, 1, "R4 fifo clear releases");

      s.wr_valid = 1; s.wr_first = 1; s.wr_pkt_start = 1; s.wr_tcode = 4'h0;
      step(5'b00000, 1, "R2 first port open");
      s.fifo_underflow = 1; step(5'b00000, 1, "R2 underflow no stall");
      s.wr_valid = 1; s.wr_first = 0; s.wr_pkt_start = 1; s.wr_tcode = 4'h4;
      step(5'b00000, 1, "R2 normal port open");
      s.fifo_underflow = 1; step(5'b00001, 1, "R2 underflow stall");
      s.fifo_underflow = 1; s.fifo_clear = 1;
      step(5'b00001, 1, "R10 stall set beats clear");
      s.fifo_clear = 1; step(5'b00000, 1, "R4 clear");
      s.fifo_underflow = 1; step(5'b00000, 1, "R2 underflow after clear");

      repeat (3) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule